// File: doc/BRIEF.md
# Steering Target Resolver

The resolver maps a register offset onto a group/instance steering pair that is sure to reach a replicated register copy that is present and powered. Several steering types each own a small table of inclusive address ranges. The offset is compared against every range at once. The lowest-numbered type that claims the offset decides how the pair is derived from that type's availability mask. An offset that no type claims gets a default pair supplied on input pins.

A three-bit bank fuse field is widened into a six-bit bank-enable mask, because each fuse bit stands for two adjacent banks. That mask serves as the availability mask for the bank-steered type, and it is also driven out. All outputs are registered, so results appear one clock after the inputs are presented. When the matched type has no available unit at all, the pair is forced to zero and an error flag is raised.

Top module: `steer_resolver`

## Requirements
- R1: While rst_ni is low, group_o, inst_o, err_o and bank_mask_o are 0 and hit_o is 7.
- R2: Every output is a registered function of the inputs sampled at the preceding rising clk_i edge. Until that edge, the outputs keep their previous values.
- R3: Range bounds are inclusive at both ends. Types take priority in the order bank (hit code 0), memory slice (1), line-cache slice (2), subslice (3), fixed-zero (4). The lowest code that claims the offset is reported on hit_o.
- R4: If no type claims the offset, group_o/inst_o equal dflt_group_i/dflt_inst_i, hit_o is 7 and err_o is 0.
- R5: Bank type: group_o is 0 and inst_o is the index of the lowest set bit of the expanded bank mask.
- R6: Memory-slice type: group_o is the index of the lowest set bit of slice_mask_i and inst_o is 0.
- R7: Line-cache-slice type: group_o is twice the lowest set index of slice_mask_i and inst_o is 0.
- R8: Subslice type: with n the lowest set index of dss_mask_i, group_o is n / DSS_PER_GRP and inst_o is n % DSS_PER_GRP (default 4).
- R9: Fixed-zero type: group_o and inst_o are 0 whatever the masks hold.
- R10: If the matched type is 0 to 3 and its availability mask is all zero, group_o and inst_o are 0 and err_o is 1.
- R11: For each set bit i of bank_fuse_i, bits 2i and 2i+1 of bank_mask_o are set. All other bits are clear.
- R12: A table entry whose valid flag is clear never matches. In the default tables, 0x1000–0x1FFF (memory slice) and 0x0B00–0x0BFF (bank) are such entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| offset_i | input | ADDR_W (24) | Register offset to resolve |
| bank_fuse_i | input | FUSE_W (3) | Bank fuse field, one bit per bank pair |
| slice_mask_i | input | SLICE_N (4) | Memory-slice availability mask |
| dss_mask_i | input | DSS_N (16) | Subslice availability mask |
| dflt_group_i | input | GRP_W (4) | Default group, used when no range matches |
| dflt_inst_i | input | INST_W (4) | Default instance, used when no range matches |
| group_o | output | GRP_W (4) | Resolved group |
| inst_o | output | INST_W (4) | Resolved instance |
| hit_o | output | 3 | Matched type code, 7 when none |
| err_o | output | 1 | Matched type has no available unit |
| bank_mask_o | output | 2*FUSE_W (6) | Expanded bank-enable mask |

## Verification
The hardest case to reach is an offset claimed by two types at once, where only the priority order decides the result. In the default tables this happens only at 0xB000–0xB0FF, which belongs to both the line-cache-slice and fixed-zero tables. Random offsets drawn from a flat space almost never land there or on an exact range bound. The stimulus therefore mixes plain random offsets with a pool of range edges and points one step outside them, including that shared window. It also forces the availability masks to zero about a quarter of the time, so the error path shows up under every type.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int NUM_TYPES = 5;

  // Order of the codes is the match priority (lowest wins)
  typedef enum logic [2:0] {
    ST_BANK  = 3'd0,
    ST_MSLC  = 3'd1,
    ST_LCSL  = 3'd2,
    ST_DSS   = 3'd3,
    ST_ZERO  = 3'd4,
    ST_NONE  = 3'd7
  } steer_type_e;
endpackage

// File: rtl/steer_first_set.sv
module steer_first_set #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  timeunit 1ns; timeprecision 1ps;

  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end

  // lowest set bit is chosen and is really set
  always_comb begin
    if (!$isunknown(vec_i) && any_o) begin
      AST_FS_BIT_SET: assert (vec_i[idx_o]);  // R3
      AST_FS_NO_LOWER: assert ((vec_i & ((W'(1) << idx_o) - W'(1))) == '0);  // R3
    end
  end
endmodule

// File: rtl/steer_range_match.sv
module steer_range_match
  import steer_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NR     = 2,
  parameter logic [NUM_TYPES-1:0][NR-1:0][ADDR_W-1:0] LO  = '0,
  parameter logic [NUM_TYPES-1:0][NR-1:0][ADDR_W-1:0] HI  = '0,
  parameter logic [NUM_TYPES-1:0][NR-1:0]             VLD = '0
) (
  input  logic [ADDR_W-1:0]    offset_i,
  output logic [NUM_TYPES-1:0] hit_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [NUM_TYPES-1:0][NR-1:0] ent_hit;

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    for (genvar r = 0; r < NR; r++) begin : g_ent
      assign ent_hit[t][r] = VLD[t][r] && (offset_i >= LO[t][r]) && (offset_i <= HI[t][r]);
    end
    assign hit_o[t] = |ent_hit[t];
  end
endmodule

// File: rtl/steer_bank_expand.sv
module steer_bank_expand #(
  parameter int FUSE_W = 3
) (
  input  logic [FUSE_W-1:0]   fuse_i,
  output logic [2*FUSE_W-1:0] mask_o
);
  timeunit 1ns; timeprecision 1ps;

  for (genvar i = 0; i < FUSE_W; i++) begin : g_pair
    assign mask_o[2*i+1:2*i] = {2{fuse_i[i]}};
  end
endmodule

// File: rtl/steer_resolver.sv
module steer_resolver
  import steer_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SLICE_N     = 4,
  parameter int DSS_N       = 16,
  parameter int DSS_PER_GRP = 4,
  parameter int FUSE_W      = 3,
  parameter int GRP_W       = 4,
  parameter int INST_W      = 4,
  parameter int NR          = 2,
  // outer index: type 4..0, inner index: entry 1..0
  parameter logic [NUM_TYPES-1:0][NR-1:0][ADDR_W-1:0] RNG_LO = '{
    '{24'h00B000, 24'h004000},
    '{24'h005500, 24'h009680},
    '{24'h00D880, 24'h00B000},
    '{24'h001000, 24'h00DD00},
    '{24'h000B00, 24'h00B100}},
  parameter logic [NUM_TYPES-1:0][NR-1:0][ADDR_W-1:0] RNG_HI = '{
    '{24'h00B0FF, 24'h0048FF},
    '{24'h007FFF, 24'h0096FF},
    '{24'h00D8FF, 24'h00B0FF},
    '{24'h001FFF, 24'h00DDFF},
    '{24'h000BFF, 24'h00B3FF}},
  parameter logic [NUM_TYPES-1:0][NR-1:0] RNG_VLD = '{2'b11, 2'b11, 2'b11, 2'b01, 2'b01}
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     offset_i,
  input  logic [FUSE_W-1:0]     bank_fuse_i,
  input  logic [SLICE_N-1:0]    slice_mask_i,
  input  logic [DSS_N-1:0]      dss_mask_i,
  input  logic [GRP_W-1:0]      dflt_group_i,
  input  logic [INST_W-1:0]     dflt_inst_i,
  output logic [GRP_W-1:0]      group_o,
  output logic [INST_W-1:0]     inst_o,
  output logic [2:0]            hit_o,
  output logic                  err_o,
  output logic [2*FUSE_W-1:0]   bank_mask_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int BANK_N   = 2 * FUSE_W;
  localparam int BANK_IW  = $clog2(BANK_N);
  localparam int SLICE_IW = (SLICE_N > 1) ? $clog2(SLICE_N) : 1;
  localparam int DSS_IW   = $clog2(DSS_N);
  localparam int TYPE_IW  = $clog2(NUM_TYPES);

  logic [BANK_N-1:0]    bank_mask;
  logic [NUM_TYPES-1:0] type_hit;
  logic [TYPE_IW-1:0]   type_idx;
  logic                 type_any;
  logic [BANK_IW-1:0]   bank_idx;
  logic                 bank_any;
  logic [SLICE_IW-1:0]  slice_idx;
  logic                 slice_any;
  logic [DSS_IW-1:0]    dss_idx;
  logic                 dss_any;

  steer_bank_expand #(.FUSE_W(FUSE_W)) u_bank (
    .fuse_i (bank_fuse_i),
    .mask_o (bank_mask)
  );

  steer_range_match #(
    .ADDR_W (ADDR_W), .NR (NR), .LO (RNG_LO), .HI (RNG_HI), .VLD (RNG_VLD)
  ) u_match (
    .offset_i (offset_i),
    .hit_o    (type_hit)
  );

  steer_first_set #(.W(NUM_TYPES), .IW(TYPE_IW)) u_prio (
    .vec_i (type_hit), .idx_o (type_idx), .any_o (type_any));
  steer_first_set #(.W(BANK_N), .IW(BANK_IW)) u_fs_bank (
    .vec_i (bank_mask), .idx_o (bank_idx), .any_o (bank_any));
  steer_first_set #(.W(SLICE_N), .IW(SLICE_IW)) u_fs_slice (
    .vec_i (slice_mask_i), .idx_o (slice_idx), .any_o (slice_any));
  steer_first_set #(.W(DSS_N), .IW(DSS_IW)) u_fs_dss (
    .vec_i (dss_mask_i), .idx_o (dss_idx), .any_o (dss_any));

  logic [GRP_W-1:0]  nxt_grp;
  logic [INST_W-1:0] nxt_inst;
  logic [2:0]        nxt_hit;
  logic              nxt_err;

  always_comb begin
    nxt_grp  = dflt_group_i;
    nxt_inst = dflt_inst_i;
    nxt_hit  = ST_NONE;
    nxt_err  = 1'b0;
    if (type_any) begin
      nxt_grp  = '0;
      nxt_inst = '0;
      nxt_hit  = 3'(type_idx);
      case (steer_type_e'(3'(type_idx)))
        ST_BANK: begin
          nxt_inst = INST_W'(bank_idx);
          nxt_err  = !bank_any;
        end
        ST_MSLC: begin
          nxt_grp = GRP_W'(slice_idx);
          nxt_err = !slice_any;
        end
        ST_LCSL: begin
          nxt_grp = GRP_W'({slice_idx, 1'b0});
          nxt_err = !slice_any;
        end
        ST_DSS: begin
          nxt_grp  = GRP_W'(32'(dss_idx) / DSS_PER_GRP);
          nxt_inst = INST_W'(32'(dss_idx) % DSS_PER_GRP);
          nxt_err  = !dss_any;
        end
        default: ;
      endcase
      if (nxt_err) begin
        nxt_grp  = '0;
        nxt_inst = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      group_o     <= '0;
      inst_o      <= '0;
      hit_o       <= ST_NONE;
      err_o       <= 1'b0;
      bank_mask_o <= '0;
    end else begin
      group_o     <= nxt_grp;
      inst_o      <= nxt_inst;
      hit_o       <= nxt_hit;
      err_o       <= nxt_err;
      bank_mask_o <= bank_mask;
    end
  end

  AST_ERR_ZERO_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (group_o == '0 && inst_o == '0));  // R10
  AST_NONE_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o == ST_NONE) |-> !err_o);  // R4
  AST_ZERO_TYPE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o == ST_ZERO) |-> (group_o == '0 && inst_o == '0 && !err_o));  // R9
  AST_LCSL_EVEN_GRP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o == ST_LCSL) |-> (group_o[0] == 1'b0 && inst_o == '0));  // R7
  AST_DSS_INST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o == ST_DSS) |-> (32'(inst_o) < DSS_PER_GRP));  // R8
  AST_BANK_PAIR_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(bank_mask_o) == 2 * $countones($past(bank_fuse_i))));  // R11
endmodule

// File: tb/tb_steer_resolver.sv
module tb_steer_resolver;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] offset;
  logic [2:0]  fuse;
  logic [3:0]  slice;
  logic [15:0] dss;
  logic [3:0]  dg, di;
  logic [3:0]  grp, inst;
  logic [2:0]  hit;
  logic        err;
  logic [5:0]  bmask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // previous expected outputs {hit, err, grp, inst, bmask}
  logic [17:0] prev_exp;

  always #2.5 clk = ~clk;

  steer_resolver dut (
    .clk_i (clk), .rst_ni (rst_n), .offset_i (offset), .bank_fuse_i (fuse),
    .slice_mask_i (slice), .dss_mask_i (dss), .dflt_group_i (dg), .dflt_inst_i (di),
    .group_o (grp), .inst_o (inst), .hit_o (hit), .err_o (err), .bank_mask_o (bmask));

  function automatic logic [2:0] ref_type(input logic [23:0] a);
    if (a >= 24'hB100 && a <= 24'hB3FF) return 3'd0;
    if (a >= 24'hDD00 && a <= 24'hDDFF) return 3'd1;
    if ((a >= 24'hB000 && a <= 24'hB0FF) || (a >= 24'hD880 && a <= 24'hD8FF)) return 3'd2;
    if ((a >= 24'h9680 && a <= 24'h96FF) || (a >= 24'h5500 && a <= 24'h7FFF)) return 3'd3;
    if ((a >= 24'h4000 && a <= 24'h48FF) || (a >= 24'hB000 && a <= 24'hB0FF)) return 3'd4;
    return 3'd7;
  endfunction

  function automatic int lowest(input logic [15:0] v, input int w);
    for (int i = 0; i < w; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [5:0] ref_bank(input logic [2:0] f);
    logic [5:0] m = '0;
    for (int i = 0; i < 3; i++) if (f[i]) m[2*i +: 2] = 2'b11;
    return m;
  endfunction

  function automatic logic [17:0] ref_out(input logic [23:0] a, input logic [2:0] f,
      input logic [3:0] s, input logic [15:0] d, input logic [3:0] g0, input logic [3:0] i0);
    logic [2:0] t = ref_type(a);
    logic [5:0] bm = ref_bank(f);
    int n;
    logic [3:0] g = '0, ii = '0;
    logic e = 1'b0;
    case (t)
      3'd0: begin n = lowest({10'b0, bm}, 6); if (n < 0) e = 1; else ii = 4'(n); end
      3'd1: begin n = lowest({12'b0, s}, 4); if (n < 0) e = 1; else g = 4'(n); end
      3'd2: begin n = lowest({12'b0, s}, 4); if (n < 0) e = 1; else g = 4'(2 * n); end
      3'd3: begin n = lowest(d, 16); if (n < 0) e = 1; else begin g = 4'(n / 4); ii = 4'(n % 4); end end
      3'd4: ;
      default: begin g = g0; ii = i0; end
    endcase
    return {t, e, g, ii, bm};
  endfunction

  function automatic string req_of(input logic [17:0] x);
    if (x[14]) return "R10";
    case (x[17:15])
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic cmp(input logic [17:0] exp, input string req);
    logic [17:0] act = {hit, err, grp, inst, bmask};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s off=%h act hit=%0d err=%0d grp=%0d inst=%0d bm=%b exp hit=%0d err=%0d grp=%0d inst=%0d bm=%b",
        req, offset, act[17:15], act[14], act[13:10], act[9:6], act[5:0],
        exp[17:15], exp[14], exp[13:10], exp[9:6], exp[5:0]);
    end
  endtask

  // drive at negedge, confirm old outputs hold (R2), check result one edge later
  task automatic apply(input logic [23:0] a, input logic [2:0] f, input logic [3:0] s,
      input logic [15:0] d, input logic [3:0] g0, input logic [3:0] i0, input string tag);
    logic [17:0] exp;
    @(negedge clk);
    offset = a; fuse = f; slice = s; dss = d; dg = g0; di = i0;
    exp = ref_out(a, f, s, d, g0, i0);
    #1;
    if (exp != prev_exp) cmp(prev_exp, "R2");
    @(negedge clk);
    cmp(exp, (tag != "") ? tag : req_of(exp));
    cmp(exp, "R11");
    prev_exp = exp;
  endtask

  function automatic logic [23:0] pick_offset();
    case ($urandom % 20)
      0:  return 24'hB100;  1:  return 24'hB3FF;  2:  return 24'hB0FF;
      3:  return 24'hB000;  4:  return 24'hB400;  5:  return 24'hDD00;
      6:  return 24'hDDFF;  7:  return 24'hD880;  8:  return 24'hD87F;
      9:  return 24'h9680;  10: return 24'h96FF;  11: return 24'h5500;
      12: return 24'h4000;  13: return 24'h48FF;  14: return 24'h1800;
      15: return 24'h0B80;  16: return 24'h7FFF;  17: return 24'h8000;
      default: return 24'($urandom % 32'h10000);
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    offset = 24'hB200; fuse = 3'b111; slice = 4'hF; dss = 16'hFFFF; dg = 4'h5; di = 4'h6;
    repeat (3) @(negedge clk);
    cmp({3'd7, 1'b0, 4'd0, 4'd0, 6'd0}, "R1");
    offset = '0; fuse = '0; slice = '0; dss = '0; dg = '0; di = '0;
    @(negedge clk);
    rst_n = 1'b1;
    prev_exp = {3'd7, 1'b0, 4'd0, 4'd0, 6'd0};
    @(negedge clk);

    // R3 bounds and priority
    apply(24'hB100, 3'b110, 4'h1, 16'h1, 4'h9, 4'h9, "R3");
    apply(24'hB3FF, 3'b100, 4'h1, 16'h1, 4'h9, 4'h9, "R3");
    apply(24'hB400, 3'b111, 4'h1, 16'h1, 4'h9, 4'hA, "R4");
    apply(24'hB0FF, 3'b111, 4'h4, 16'h1, 4'h9, 4'h9, "R3");
    apply(24'hB000, 3'b111, 4'h8, 16'h1, 4'h9, 4'h9, "R7");
    apply(24'hDD80, 3'b000, 4'h8, 16'h1, 4'h0, 4'h0, "R6");
    apply(24'h9680, 3'b001, 4'h1, 16'h0200, 4'h0, 4'h0, "R8");
    apply(24'h7FFF, 3'b001, 4'h1, 16'h8000, 4'h0, 4'h0, "R8");
    apply(24'h4000, 3'b000, 4'h0, 16'h0, 4'hF, 4'hF, "R9");
    // R12 disabled entries
    apply(24'h1800, 3'b111, 4'hF, 16'hFFFF, 4'h3, 4'h2, "R12");
    apply(24'h0B80, 3'b111, 4'hF, 16'hFFFF, 4'h1, 4'h7, "R12");
    // R10 empty masks
    apply(24'hB200, 3'b000, 4'hF, 16'hFFFF, 4'h3, 4'h3, "R10");
    apply(24'hD8FF, 3'b111, 4'h0, 16'hFFFF, 4'h3, 4'h3, "R10");
    apply(24'h6000, 3'b111, 4'hF, 16'h0000, 4'h3, 4'h3, "R10");
    apply(24'hDD00, 3'b111, 4'h0, 16'hFFFF, 4'h3, 4'h3, "R10");

    for (int k = 0; k < 400; k++) begin
      logic [2:0]  f = 3'($urandom);
      logic [3:0]  s = 4'($urandom);
      logic [15:0] d = 16'($urandom);
      if ($urandom % 4 == 0) f = '0;
      if ($urandom % 4 == 0) s = '0;
      if ($urandom % 4 == 0) d = '0;
      apply(pick_offset(), f, s, d, 4'($urandom), 4'($urandom), "");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule